// File: doc/BRIEF.md
# Host Tuning Command Parser

This block sits behind a host byte link in a receiver. It builds fixed five-byte commands out of the incoming bytes. Each command is an opcode byte followed by a 32-bit argument, sent most significant byte first. Two opcodes are decoded:

- The tune opcode loads a new centre frequency.
- The rate opcode loads a new sample rate. It also recomputes the output gain and the sample-timer divisor from that rate.

Both opcodes raise a one-cycle retune pulse for the local-oscillator logic downstream. A zero byte that arrives where an opcode is expected does not start a frame. It is a stop request: streaming ends and the byte is discarded.

When the block is idle, any completed command starts streaming. A start pulse is raised and a fixed 12-byte stream header goes out, one byte per cycle, for the output path to forward ahead of the sample data. Further commands received while streaming update the registers but do not restart the stream.

Top module: `tune_cmd_parser`

## Requirements
- R1: A synchronous reset sets these values: byte position 0, `freq_q` = 94,600,000, `rate_q` = 100,000, `gain_q` = 10, `tdiv_q` = 800. It also clears `streaming`, `hdr_valid` and all pulses.
- R2: Opcode 0x01 followed by four argument bytes, most significant first, loads the argument into `freq_q`. `retune_p` is high for exactly the one cycle after the fifth byte is accepted.
- R3: Opcode 0x02 loads the argument into `rate_q` and raises `retune_p`. It sets `gain_q` = 32768 / (CLK_HZ / rate) and `tdiv_q` = CLK_HZ / (rate * 4), with CLK_HZ = 320,000,000. Outside such a frame, none of these three outputs changes.
- R4: A zero byte accepted at byte position 0 is not stored. It raises `stop_p` for one cycle and clears `streaming`, and the next byte is taken as an opcode.
- R5: A zero byte in argument positions 1 to 4 is ordinary data.
- R6: A frame with any other non-zero opcode is consumed. It changes no output register and raises no `retune_p`.
- R7: A completed frame that arrives while `streaming` is low raises `start_p` for one cycle and sets `streaming`. A frame that completes while streaming raises no `start_p`.
- R8: From the cycle in which `start_p` is high, `hdr_valid` stays high for 12 consecutive cycles. In those cycles `hdr_byte` carries 52 54 4C 30 00 00 00 05 00 00 00 1D, and `hdr_valid` then falls.
- R9: A stop request accepted while the header is going out ends it: `hdr_valid` is low from the cycle `stop_p` is high.
- R10: A rate of 0 is computed as a rate of 1. When CLK_HZ / rate is 0, `gain_q` takes 32768, and `tdiv_q` is then 0.
- R11: Bytes presented while `rx_valid` is low are ignored and do not advance the byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | `rx_byte` holds a new host byte this cycle |
| rx_byte | input | 8 | Host byte |
| freq_q | output | 32 | Registered centre frequency |
| rate_q | output | 32 | Registered sample rate |
| gain_q | output | 32 | Gain derived from the sample rate |
| tdiv_q | output | 32 | Sample-timer divisor derived from the sample rate |
| retune_p | output | 1 | One-cycle pulse when frequency or rate is loaded |
| start_p | output | 1 | One-cycle pulse when streaming begins |
| stop_p | output | 1 | One-cycle pulse on a stop request |
| streaming | output | 1 | Streaming is active |
| hdr_valid | output | 1 | `hdr_byte` carries a header byte |
| hdr_byte | output | 8 | Stream header byte |

## Verification
Directed frames are used to tell byte order apart from byte position:

- arguments with distinct byte values;
- arguments made of zero bytes, so that a zero in data cannot be mistaken for a stop;
- a stop byte between frames;
- a stop byte in the middle of the header.

Random frames then mix the two decoded opcodes with unknown opcodes and with idle gaps that carry garbage on `rx_byte`. This separates byte counting from whatever is on the data lines. Extreme rates (0, all ones, and a normal value) test the guarded division against the plain formula.

// File: rtl/tune_cmd_parser.sv
module tune_cmd_parser #(
  parameter int unsigned CLK_HZ    = 320_000_000,
  parameter int unsigned DECIM     = 4,
  parameter int unsigned BASE_GAIN = 32768,
  parameter int unsigned DEF_FREQ  = 94_600_000,
  parameter int unsigned DEF_RATE  = 100_000
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic [31:0] freq_q,
  output logic [31:0] rate_q,
  output logic [31:0] gain_q,
  output logic [31:0] tdiv_q,
  output logic        retune_p,
  output logic        start_p,
  output logic        stop_p,
  output logic        streaming,
  output logic        hdr_valid,
  output logic [7:0]  hdr_byte
);
  localparam int unsigned FRAME_BYTES = 5;
  localparam int unsigned HDR_BYTES   = 12;
  localparam int PW = $clog2(FRAME_BYTES);
  localparam int HW = $clog2(HDR_BYTES);
  localparam logic [PW-1:0] POS_LAST = PW'(FRAME_BYTES - 1);
  localparam logic [HW-1:0] HDR_LAST = HW'(HDR_BYTES - 1);
  localparam logic [7:0]  OP_TUNE = 8'h01;
  localparam logic [7:0]  OP_RATE = 8'h02;
  localparam logic [31:0] HDR_MAGIC = 32'h5254_4C30;
  localparam logic [31:0] HDR_KIND  = 32'd5;
  localparam logic [31:0] HDR_INFO  = 32'd29;

  function automatic logic [31:0] gain_of(logic [31:0] r);
    logic [63:0] rr, q;
    rr = (r == 32'd0) ? 64'd1 : {32'd0, r};
    q  = 64'(CLK_HZ) / rr;
    return (q == 64'd0) ? 32'(BASE_GAIN) : 32'(64'(BASE_GAIN) / q);
  endfunction

  function automatic logic [31:0] tdiv_of(logic [31:0] r);
    logic [63:0] rr;
    rr = (r == 32'd0) ? 64'd1 : {32'd0, r};
    return 32'(64'(CLK_HZ) / (rr * 64'(DECIM)));
  endfunction

  function automatic logic [7:0] hdr_of(logic [HW-1:0] i);
    logic [31:0] w;
    case (i[HW-1:2])
      2'd0:    w = HDR_MAGIC;
      2'd1:    w = HDR_KIND;
      default: w = HDR_INFO;
    endcase
    return 8'(w >> {~i[1:0], 3'b000});
  endfunction

  logic [PW-1:0] pos;
  logic [7:0]    opc;
  logic [23:0]   argsh;
  logic [HW-1:0] hdr_idx;
  logic [31:0]   arg_full;

  assign arg_full = {argsh, rx_byte};
  assign hdr_byte = hdr_valid ? hdr_of(hdr_idx) : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= '0;
      opc       <= '0;
      argsh     <= '0;
      freq_q    <= 32'(DEF_FREQ);
      rate_q    <= 32'(DEF_RATE);
      gain_q    <= gain_of(32'(DEF_RATE));
      tdiv_q    <= tdiv_of(32'(DEF_RATE));
      retune_p  <= 1'b0;
      start_p   <= 1'b0;
      stop_p    <= 1'b0;
      streaming <= 1'b0;
      hdr_valid <= 1'b0;
      hdr_idx   <= '0;
    end else begin
      retune_p <= 1'b0;
      start_p  <= 1'b0;
      stop_p   <= 1'b0;
      if (hdr_valid) begin
        if (hdr_idx == HDR_LAST) hdr_valid <= 1'b0;
        else                     hdr_idx   <= hdr_idx + 1'b1;
      end
      if (rx_valid) begin
        if (pos == '0 && rx_byte == 8'h00) begin
          stop_p    <= 1'b1;
          streaming <= 1'b0;
          hdr_valid <= 1'b0;
        end else if (pos == POS_LAST) begin
          pos <= '0;
          if (opc == OP_TUNE) begin
            freq_q   <= arg_full;
            retune_p <= 1'b1;
          end else if (opc == OP_RATE) begin
            rate_q   <= arg_full;
            gain_q   <= gain_of(arg_full);
            tdiv_q   <= tdiv_of(arg_full);
            retune_p <= 1'b1;
          end
          if (!streaming) begin
            start_p   <= 1'b1;
            streaming <= 1'b1;
            hdr_valid <= 1'b1;
            hdr_idx   <= '0;
          end
        end else begin
          pos <= pos + 1'b1;
          if (pos == '0) opc   <= rx_byte;
          else           argsh <= {argsh[15:0], rx_byte};
        end
      end
    end
  end
endmodule

module tune_cmd_parser_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] freq_q,
  input logic [31:0] rate_q,
  input logic [31:0] gain_q,
  input logic [31:0] tdiv_q,
  input logic        retune_p,
  input logic        start_p,
  input logic        stop_p,
  input logic        streaming,
  input logic        hdr_valid,
  input logic [7:0]  hdr_byte
);
  assert_retune_single_R2: assert property (@(posedge clk) disable iff (rst)
    retune_p |=> !retune_p);
  assert_freq_only_on_retune_R2: assert property (@(posedge clk) disable iff (rst)
    !retune_p |-> $stable(freq_q));
  assert_rate_only_on_retune_R3: assert property (@(posedge clk) disable iff (rst)
    !retune_p |-> ($stable(rate_q) && $stable(gain_q) && $stable(tdiv_q)));
  assert_stop_clears_stream_R4: assert property (@(posedge clk) disable iff (rst)
    stop_p |-> (!streaming && !start_p));
  assert_start_from_idle_R7: assert property (@(posedge clk) disable iff (rst)
    start_p |-> (streaming && !$past(streaming)));
  assert_header_first_byte_R8: assert property (@(posedge clk) disable iff (rst)
    start_p |-> (hdr_valid && hdr_byte == 8'h52));
  assert_header_abort_R9: assert property (@(posedge clk) disable iff (rst)
    stop_p |-> !hdr_valid);
endmodule

bind tune_cmd_parser tune_cmd_parser_chk chk_i (
  .clk(clk), .rst(rst), .freq_q(freq_q), .rate_q(rate_q), .gain_q(gain_q),
  .tdiv_q(tdiv_q), .retune_p(retune_p), .start_p(start_p), .stop_p(stop_p),
  .streaming(streaming), .hdr_valid(hdr_valid), .hdr_byte(hdr_byte)
);

// File: tb/tune_cmd_parser_tb_top.sv
module tune_cmd_parser_tb_top;
  localparam longint CLKHZ = 320_000_000;
  localparam longint BGAIN = 32768;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [31:0] freq_q, rate_q, gain_q, tdiv_q;
  logic retune_p, start_p, stop_p, streaming, hdr_valid;
  logic [7:0] hdr_byte;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_freq, m_rate;
  bit m_stream;

  always #5 clk = ~clk;

  tune_cmd_parser dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .freq_q(freq_q), .rate_q(rate_q), .gain_q(gain_q), .tdiv_q(tdiv_q),
    .retune_p(retune_p), .start_p(start_p), .stop_p(stop_p),
    .streaming(streaming), .hdr_valid(hdr_valid), .hdr_byte(hdr_byte)
  );

  function automatic logic [31:0] exp_gain(logic [31:0] r);
    longint unsigned d, q;
    d = (r == 0) ? 1 : longint'(r);
    q = CLKHZ / d;
    if (q == 0) return 32'(BGAIN);
    return 32'(BGAIN / q);
  endfunction

  function automatic logic [31:0] exp_tdiv(logic [31:0] r);
    longint unsigned d;
    d = (r == 0) ? 1 : longint'(r);
    return 32'(CLKHZ / (d * 4));
  endfunction

  function automatic logic [7:0] exp_hdr(int i);
    logic [7:0] t [12] = '{8'h52, 8'h54, 8'h4C, 8'h30, 8'h00, 8'h00, 8'h00, 8'h05,
                           8'h00, 8'h00, 8'h00, 8'h1D};
    return t[i];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_byte  = 8'($urandom);
  endtask

  task automatic gap(int n);
    for (int i = 0; i < n; i++) begin
      rx_byte = 8'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic send_frame(logic [7:0] op, logic [31:0] a, int maxgap);
    send_byte(op);
    for (int i = 3; i >= 0; i--) begin
      if (maxgap > 0) gap($urandom_range(maxgap, 0));
      send_byte(a[8*i +: 8]);
    end
  endtask

  task automatic check_frame(string req, logic [7:0] op, logic [31:0] a);
    bit was_stream = m_stream;
    if (op == 8'h01) m_freq = a;
    if (op == 8'h02) m_rate = a;
    chk({req, " retune"}, 32'(retune_p), 32'(op == 8'h01 || op == 8'h02));
    chk({req, " R7 start"}, 32'(start_p), 32'(!was_stream));
    m_stream = 1'b1;
    chk({req, " freq"}, freq_q, m_freq);
    chk({req, " rate"}, rate_q, m_rate);
    chk({req, " gain"}, gain_q, exp_gain(m_rate));
    chk({req, " tdiv"}, tdiv_q, exp_tdiv(m_rate));
    chk({req, " streaming"}, 32'(streaming), 32'(m_stream));
  endtask

  task automatic do_stop(string req);
    send_byte(8'h00);
    m_stream = 1'b0;
    chk({req, " stop_p"}, 32'(stop_p), 32'd1);
    chk({req, " streaming"}, 32'(streaming), 32'd0);
    chk({req, " R9 hdr_valid"}, 32'(hdr_valid), 32'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] op;
    logic [31:0] a;
    void'($urandom(32'd20250704));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    m_freq = 32'd94_600_000;
    m_rate = 32'd100_000;
    m_stream = 1'b0;

    // R1 reset state
    chk("R1 freq", freq_q, 32'd94_600_000);
    chk("R1 rate", rate_q, 32'd100_000);
    chk("R1 gain", gain_q, 32'd10);
    chk("R1 tdiv", tdiv_q, 32'd800);
    chk("R1 flags", {27'd0, retune_p, start_p, stop_p, streaming, hdr_valid}, 32'd0);

    // R2 R7 R8: tune frame from idle, then full header
    send_frame(8'h01, 32'h05A3_E100, 0);
    check_frame("R2", 8'h01, 32'h05A3_E100);
    for (int i = 0; i < 12; i++) begin
      chk("R8 hdr_valid", 32'(hdr_valid), 32'd1);
      chk("R8 hdr_byte", 32'(hdr_byte), 32'(exp_hdr(i)));
      @(negedge clk);
    end
    chk("R8 hdr end", 32'(hdr_valid), 32'd0);
    chk("R2 retune single", 32'(retune_p), 32'd0);

    // R7 while streaming: no restart
    send_frame(8'h01, 32'h1234_5678, 0);
    check_frame("R7", 8'h01, 32'h1234_5678);
    chk("R7 no header", 32'(hdr_valid), 32'd0);

    // R3 rate frame
    send_frame(8'h02, 32'd250_000, 0);
    check_frame("R3", 8'h02, 32'd250_000);
    chk("R3 gain value", gain_q, 32'd25);
    chk("R3 tdiv value", tdiv_q, 32'd320);

    // R5 zero bytes as argument data
    send_frame(8'h01, 32'h0000_0000, 0);
    check_frame("R5", 8'h01, 32'h0);

    // R6 unknown opcode
    send_frame(8'h7F, 32'hDEAD_BEEF, 0);
    check_frame("R6", 8'h7F, 32'hDEAD_BEEF);

    // R4 stop, then next byte is an opcode
    do_stop("R4");
    send_frame(8'h01, 32'h0102_0304, 0);
    check_frame("R4 after stop", 8'h01, 32'h0102_0304);

    // R9 stop during header
    chk("R9 header running", 32'(hdr_valid), 32'd1);
    @(negedge clk);
    @(negedge clk);
    chk("R9 third byte", 32'(hdr_byte), 32'h4C);
    do_stop("R9");

    // R10 guarded rates
    send_frame(8'h02, 32'h0, 0);
    check_frame("R10 zero", 8'h02, 32'h0);
    chk("R10 gain zero rate", gain_q, 32'd0);
    chk("R10 tdiv zero rate", tdiv_q, 32'd80_000_000);
    send_frame(8'h02, 32'hFFFF_FFFF, 0);
    check_frame("R10 max", 8'h02, 32'hFFFF_FFFF);
    chk("R10 gain max rate", gain_q, 32'd32768);
    chk("R10 tdiv max rate", tdiv_q, 32'd0);

    // R11 gaps with garbage
    send_frame(8'h01, 32'hCAFE_0001, 5);
    check_frame("R11", 8'h01, 32'hCAFE_0001);

    // random mix
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(9, 0) == 0) begin
        do_stop("R4 rand");
      end else begin
        case ($urandom_range(3, 0))
          0:       op = 8'h01;
          1:       op = 8'h02;
          2:       op = 8'($urandom_range(255, 3));
          default: op = $urandom_range(1, 0) ? 8'h01 : 8'h02;
        endcase
        a = $urandom;
        if ($urandom_range(3, 0) == 0) a = 32'($urandom_range(2_000_000, 0));
        send_frame(op, a, $urandom_range(3, 0));
        check_frame("R11 rand", op, a);
      end
      gap($urandom_range(2, 0));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule